// File: doc/BRIEF.md
# 16/32-bit Bus Sizing Sequencer

This block sits between a source of 32-bit bus cycles and the external bus. For every cycle it samples a per-cycle narrow-port indication, `narrow_n`, which is low when the addressed device is only 16 bits wide. When that indication matters, the block adapts the transfer. A read that touches only the upper two lanes is steered so that its bytes come from the low half of the data bus. A transfer that touches both halves becomes two bus cycles: the low half goes first, then the high half, both on the low 16 data lines. A write that touches only the upper lanes always carries its upper half on both halves of the bus, so it never needs a second cycle.

Each bus cycle has one address clock (`bus_start`) followed by one or more data clocks. The cycle ends in the data clock where `ack_n` is sampled low, and `narrow_n` is sampled in that same clock. For a split read, the block holds the two low bytes from the first cycle and merges them with the bytes from the second cycle. It then issues a single `done` pulse carrying the assembled word. If the device stops reporting itself as narrow in the second half of a split, the block raises `proto_err`.

Top module: `bus_sizer`

## Requirements
- R1: After reset and whenever no cycle is in progress, `bus_cyc` is low, `bus_be_n` is all ones, `bus_drive` is low, `req_ready` is high and `done` is low. `bus_dout` is zero whenever `bus_drive` is low.
- R2: Every bus cycle has exactly one clock with `bus_start` high, followed by data clocks with `bus_start` low. `ack_n` is sampled only in data clocks, so a cycle lasts 2 clocks plus one clock per data clock that ends with `ack_n` high.
- R3: When lanes 2 and 3 are both disabled (`req_be_n[3:2]` = 11), the transfer is a single bus cycle whatever the value of `narrow_n`.
- R4: When `narrow_n` is high at the end of the cycle, the transfer is a single bus cycle. Each enabled lane of `rd_data` comes from the same lane of `bus_din`.
- R5: For a read that enables only lanes 2 and/or 3, with `narrow_n` low at the end of the cycle, `rd_data` bits 31:16 are taken from `bus_din[15:0]`, and `bus_din[31:16]` is ignored.
- R6: For a write that enables only lanes 2 and/or 3, `bus_dout` carries `wdata[31:16]` on both halves. The transfer takes one bus cycle regardless of `narrow_n`.
- R7: When at least one of lanes 0–1 and at least one of lanes 2–3 are enabled, and `narrow_n` is low when the first cycle ends, a second bus cycle starts on the next clock. It uses the same address and direction, keeps `bus_be_n[3:2]` unchanged and sets `bus_be_n[1:0]` to 11.
- R8: For a split read, `rd_data[15:0]` comes from `bus_din[15:0]` of the first cycle and `rd_data[31:16]` comes from `bus_din[15:0]` of the second cycle.
- R9: For a split write, the first cycle drives the full write word. The second cycle drives `wdata[31:16]` on both halves.
- R10: If `narrow_n` is high when the second cycle of a split ends, `proto_err` is high in the same clock as `done`. The data is still taken from `bus_din[15:0]`.
- R11: `done` is a one-clock pulse in the clock after the final acknowledge. In that clock `rd_data` holds the result, with zero in lanes whose byte enable is high and zero for writes.
- R12: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and `bus_start` is high in the following clock. `req_ready` is already high in the clock that carries `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can accept a request |
| req_addr | input | ADDR_W | Doubleword address |
| req_be_n | input | 4 | Active-low byte enables, bit i selects lane i (bits 8i+7:8i) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4*BYTE_W | Write data |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_be_n | output | 4 | Byte enables driven on the bus |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_start | output | 1 | Address clock of a bus cycle |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_dout | output | 4*BYTE_W | Data driven on writes |
| bus_drive | output | 1 | Data bus driver enable |
| bus_din | input | 4*BYTE_W | Data returned on reads |
| ack_n | input | 1 | Active-low cycle end |
| narrow_n | input | 1 | Active-low 16-bit port indication |
| rd_data | output | 4*BYTE_W | Assembled read result |
| done | output | 1 | Transfer complete pulse |
| proto_err | output | 1 | Narrow indication dropped in second half of a split |

## Verification
The completion pulse of one transfer and the acceptance of the next request can fall in the same clock, because `req_ready` rises in the clock that carries `done`. The bench provokes this by holding a lower-lane read in flight and presenting a split read at the exact negative edge where `done` is seen. It then checks that `req_ready` is high there and that `bus_start` follows one clock later. The scoreboard verifies that both results arrive in order, with the second result built from two narrow cycles.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

   localparam int LANES = 4;
   localparam int HALF  = LANES / 2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

endpackage

// File: rtl/bsz_lane_class.sv
module bsz_lane_class
   import bsz_pkg::*;
#(
   parameter int NLANE = LANES
) (
   input  logic [NLANE-1:0] be_n,
   output logic             lo_any,
   output logic             hi_any,
   output logic             hi_only
);
   localparam int NHALF = NLANE / 2;

   logic [NHALF-1:0] lo_en;
   logic [NHALF-1:0] hi_en;

   for (genvar i = 0; i < NHALF; i++) begin : g_half
      assign lo_en[i] = ~be_n[i];
      assign hi_en[i] = ~be_n[i+NHALF];
   end

   assign lo_any  = |lo_en;
   assign hi_any  = |hi_en;
   assign hi_only = hi_any & ~lo_any;

endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
   import bsz_pkg::*;
#(
   parameter bit ERR_CHECK = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   ack_n,
   input  logic   narrow_n,
   input  logic   lo_any,
   input  logic   hi_any,
   output phase_e phase,
   output logic   second,
   output logic   take,
   output logic   latch_lo,
   output logic   finish,
   output logic   err_now,
   output logic   narrow_hi,
   output logic   req_ready
);
   logic in_data;
   logic acked;
   logic need_split;

   assign in_data    = (phase == PH_DATA);
   assign acked      = in_data & ~ack_n;
   assign need_split = lo_any & hi_any & ~narrow_n & ~second;

   assign req_ready = (phase == PH_IDLE);
   assign take      = req_ready & req_valid;
   assign latch_lo  = acked & need_split;
   assign finish    = acked & ~need_split;
   assign narrow_hi = ~second & hi_any & ~lo_any & ~narrow_n;

   if (ERR_CHECK) begin : g_err_on
      assign err_now = finish & second & narrow_n;
   end else begin : g_err_off
      assign err_now = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         second <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  phase  <= PH_ADDR;
                  second <= 1'b0;
               end
            end
            PH_ADDR: phase <= PH_DATA;
            PH_DATA: begin
               if (!ack_n) begin
                  if (need_split) begin
                     phase  <= PH_ADDR;
                     second <= 1'b1;
                  end else begin
                     phase  <= PH_IDLE;
                     second <= 1'b0;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
   import bsz_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [LANES*BYTE_W-1:0] wdata,
   input  logic                    dup,
   input  logic                    drive,
   output logic [LANES*BYTE_W-1:0] dout
);
   localparam int HW = HALF * BYTE_W;

   logic [HW-1:0] upper;
   logic [HW-1:0] lower;

   assign upper = wdata[2*HW-1:HW];
   assign lower = dup ? upper : wdata[HW-1:0];
   assign dout  = drive ? {upper, lower} : '0;

endmodule

// File: rtl/bsz_rd_merge.sv
module bsz_rd_merge
   import bsz_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES*BYTE_W-1:0] din,
   input  logic [LANES-1:0]        be_n,
   input  logic                    write,
   input  logic                    second,
   input  logic                    narrow_hi,
   input  logic                    latch_lo,
   output logic [LANES*BYTE_W-1:0] merged
);
   localparam int HW = HALF * BYTE_W;

   logic [HW-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lo_q <= '0;
      else if (latch_lo) lo_q <= din[HW-1:0];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [BYTE_W-1:0] pick;
      if (i < HALF) begin : g_lo
         assign pick = second ? lo_q[i*BYTE_W +: BYTE_W] : din[i*BYTE_W +: BYTE_W];
      end else begin : g_hi
         localparam int SRC = i - HALF;
         assign pick = (second | narrow_hi) ? din[SRC*BYTE_W +: BYTE_W]
                                            : din[i*BYTE_W +: BYTE_W];
      end
      assign merged[i*BYTE_W +: BYTE_W] = (be_n[i] | write) ? '0 : pick;
   end

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
   import bsz_pkg::*;
#(
   parameter int ADDR_W    = 30,
   parameter int BYTE_W    = 8,
   parameter bit ERR_CHECK = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [3:0]            req_be_n,
   input  logic                  req_write,
   input  logic [4*BYTE_W-1:0]   req_wdata,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [3:0]            bus_be_n,
   output logic                  bus_write,
   output logic                  bus_start,
   output logic                  bus_cyc,
   output logic [4*BYTE_W-1:0]   bus_dout,
   output logic                  bus_drive,
   input  logic [4*BYTE_W-1:0]   bus_din,
   input  logic                  ack_n,
   input  logic                  narrow_n,
   output logic [4*BYTE_W-1:0]   rd_data,
   output logic                  done,
   output logic                  proto_err
);
   localparam int DATA_W = LANES * BYTE_W;

   if (ADDR_W < 1 || ADDR_W > 62) begin : g_bad_addr
      $error("bus_sizer: ADDR_W out of range");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("bus_sizer: BYTE_W must be positive");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("bus_sizer: lane count must be four");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  be_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;

   phase_e phase;
   logic second, take, latch_lo, finish, err_now, narrow_hi;
   logic lo_any, hi_any, hi_only;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] steer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         be_q    <= '1;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else if (take) begin
         addr_q  <= req_addr;
         be_q    <= req_be_n;
         wr_q    <= req_write;
         wdata_q <= req_wdata;
      end
   end

   bsz_lane_class #(.NLANE(LANES)) u_class (
      .be_n    (be_q),
      .lo_any  (lo_any),
      .hi_any  (hi_any),
      .hi_only (hi_only)
   );

   bsz_seq #(.ERR_CHECK(ERR_CHECK)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .ack_n     (ack_n),
      .narrow_n  (narrow_n),
      .lo_any    (lo_any),
      .hi_any    (hi_any),
      .phase     (phase),
      .second    (second),
      .take      (take),
      .latch_lo  (latch_lo),
      .finish    (finish),
      .err_now   (err_now),
      .narrow_hi (narrow_hi),
      .req_ready (req_ready)
   );

   assign bus_cyc   = (phase != PH_IDLE);
   assign bus_start = (phase == PH_ADDR);
   assign bus_addr  = addr_q;
   assign bus_write = wr_q;
   assign bus_drive = bus_cyc & wr_q;

   always_comb begin
      if (!bus_cyc)    bus_be_n = '1;
      else if (second) bus_be_n = {be_q[LANES-1:HALF], {HALF{1'b1}}};
      else             bus_be_n = be_q;
   end

   bsz_wr_steer #(.BYTE_W(BYTE_W)) u_steer (
      .wdata (wdata_q),
      .dup   (second | hi_only),
      .drive (bus_drive),
      .dout  (steer)
   );
   assign bus_dout = steer;

   bsz_rd_merge #(.BYTE_W(BYTE_W)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (bus_din),
      .be_n      (be_q),
      .write     (wr_q),
      .second    (second),
      .narrow_hi (narrow_hi),
      .latch_lo  (latch_lo),
      .merged    (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         done      <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         done      <= finish;
         proto_err <= err_now;
         if (finish) rd_data <= merged;
      end
   end

endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_cyc,
   input logic                bus_start,
   input logic [3:0]          bus_be_n,
   input logic                bus_drive,
   input logic [4*BYTE_W-1:0] bus_dout,
   input logic                ack_n,
   input logic                narrow_n,
   input logic                done,
   input logic                proto_err
);
   localparam int HW = 2 * BYTE_W;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cyc |-> (bus_be_n == 4'hF && !bus_drive)); // R1

   AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (bus_cyc && !bus_start)); // R2

   AST_LOW_ONLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_start && !ack_n && bus_be_n[3:2] == 2'b11) |=> !bus_cyc); // R3

   AST_WR_DUP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && bus_be_n[1:0] == 2'b11) |-> bus_dout[2*HW-1:HW] == bus_dout[HW-1:0]); // R6

   AST_SECOND_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_start && !ack_n && !narrow_n &&
       bus_be_n[1:0] != 2'b11 && bus_be_n[3:2] != 2'b11)
      |=> (bus_start && bus_be_n[1:0] == 2'b11)); // R7

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> done); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(!ack_n) && $past(bus_cyc))); // R11

endmodule

bind bus_sizer bus_sizer_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cyc   (bus_cyc),
   .bus_start (bus_start),
   .bus_be_n  (bus_be_n),
   .bus_drive (bus_drive),
   .bus_dout  (bus_dout),
   .ack_n     (ack_n),
   .narrow_n  (narrow_n),
   .done      (done),
   .proto_err (proto_err)
);

// File: tb/bus_sizer_test.sv
`timescale 1ns/1ps
module bus_sizer_test;
   localparam int AW = 30;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid, req_ready, req_write;
   logic [AW-1:0] req_addr;
   logic [3:0]    req_be_n;
   logic [DW-1:0] req_wdata;
   logic [AW-1:0] bus_addr;
   logic [3:0]    bus_be_n;
   logic          bus_write, bus_start, bus_cyc, bus_drive;
   logic [DW-1:0] bus_dout, bus_din, rd_data;
   logic          ack_n, narrow_n, done, proto_err;

   bus_sizer #(.ADDR_W(AW), .BYTE_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_be_n(req_be_n), .req_write(req_write),
      .req_wdata(req_wdata), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
      .bus_write(bus_write), .bus_start(bus_start), .bus_cyc(bus_cyc),
      .bus_dout(bus_dout), .bus_drive(bus_drive), .bus_din(bus_din),
      .ack_n(ack_n), .narrow_n(narrow_n), .rd_data(rd_data), .done(done),
      .proto_err(proto_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [DW-1:0] data;
      logic          err;
      string         tag;
   } res_t;
   typedef struct {
      logic [AW-1:0] addr;
      logic [3:0]    be_n;
      logic          wr;
      logic [DW-1:0] dout;
      string         tag;
   } cyc_t;
   res_t res_q[$];
   cyc_t cyc_q[$];

   int            cfg_wait = 0;
   logic          cfg_n1 = 1'b1;
   logic          cfg_n2 = 1'b0;
   logic [DW-1:0] cfg_d1 = '0;
   logic [DW-1:0] cfg_d2 = '0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // bus responder: acknowledges in the address clock as a trap, then after cfg_wait data clocks
   int rsp_idx = 0;
   int rsp_cnt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         ack_n = 1'b1; narrow_n = 1'b1; bus_din = '0; rsp_idx = 0; rsp_cnt = 0;
      end else if (bus_start) begin
         ack_n = 1'b0; narrow_n = 1'b0; bus_din = 32'hDEAD_BEEF; rsp_cnt = 0;
      end else if (bus_cyc) begin
         if (rsp_cnt == cfg_wait) begin
            ack_n    = 1'b0;
            narrow_n = (rsp_idx == 0) ? cfg_n1 : cfg_n2;
            bus_din  = (rsp_idx == 0) ? cfg_d1 : cfg_d2;
            rsp_idx++;
         end else begin
            ack_n = 1'b1; narrow_n = 1'b0; bus_din = 32'h5A5A_5A5A;
         end
         rsp_cnt++;
      end else begin
         ack_n = 1'b1; narrow_n = 1'b1; rsp_idx = 0;
      end
   end

   // monitor: pops expected bus cycles and results
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_start) begin
            if (cyc_q.size() == 0) begin
               check(1'b0, "R7", "unexpected bus cycle be_n", {60'd0, bus_be_n}, 64'hF);
            end else begin
               cyc_t c;
               c = cyc_q.pop_front();
               check(bus_be_n == c.be_n, c.tag, "bus_be_n", {60'd0, bus_be_n}, {60'd0, c.be_n});
               check(bus_addr == c.addr, c.tag, "bus_addr", {34'd0, bus_addr}, {34'd0, c.addr});
               check(bus_write == c.wr, c.tag, "bus_write", {63'd0, bus_write}, {63'd0, c.wr});
               check(bus_dout == c.dout, c.tag, "bus_dout", {32'd0, bus_dout}, {32'd0, c.dout});
            end
         end
         if (done) begin
            if (res_q.size() == 0) begin
               check(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
            end else begin
               res_t r;
               r = res_q.pop_front();
               check(rd_data == r.data, r.tag, "rd_data", {32'd0, rd_data}, {32'd0, r.data});
               check(proto_err == r.err, r.tag, "proto_err", {63'd0, proto_err}, {63'd0, r.err});
            end
         end
      end
   end

   function automatic int push_exp(input logic [AW-1:0] a, input logic wr, input logic [3:0] be,
                                   input logic [DW-1:0] w, input string tag);
      logic lo, hi, split;
      logic [DW-1:0] raw, dup;
      cyc_t c;
      res_t r;
      lo = (be[1:0] != 2'b11);
      hi = (be[3:2] != 2'b11);
      split = lo && hi && !cfg_n1;
      dup = {w[31:16], w[31:16]};
      c.addr = a; c.wr = wr; c.tag = tag; c.be_n = be;
      c.dout = wr ? ((hi && !lo) ? dup : w) : '0;
      cyc_q.push_back(c);
      if (split) begin
         c.be_n = {be[3:2], 2'b11};
         c.dout = wr ? dup : '0;
         cyc_q.push_back(c);
      end
      if (split)                   raw = {cfg_d2[15:0], cfg_d1[15:0]};
      else if (hi && !lo && !cfg_n1) raw = {cfg_d1[15:0], cfg_d1[15:0]};
      else                         raw = cfg_d1;
      for (int i = 0; i < 4; i++)
         if (be[i] || wr) raw[i*8 +: 8] = 8'h00;
      r.data = raw;
      r.err  = split && cfg_n2;
      r.tag  = tag;
      res_q.push_back(r);
      return split ? 2 : 1;
   endfunction

   task automatic xfer(input logic [AW-1:0] a, input logic wr, input logic [3:0] be,
                       input logic [DW-1:0] w, input string tag);
      int ncyc;
      int k;
      ncyc = push_exp(a, wr, be, w, tag);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_write = wr; req_be_n = be; req_wdata = w; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      k = 0;
      while (!done) begin
         @(negedge clk);
         k++;
      end
      // R2: latency equals the bus cycles' lengths
      check(k == ncyc * (2 + cfg_wait), "R2", "clocks to done", 64'(k), 64'(ncyc * (2 + cfg_wait)));
   endtask

   bit finished = 1'b0;

   initial begin
      #(8 * 40000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_be_n = 4'hF; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!bus_cyc, "R1", "bus_cyc", {63'd0, bus_cyc}, 64'd0);
      check(bus_be_n == 4'hF, "R1", "bus_be_n", {60'd0, bus_be_n}, 64'hF);
      check(!bus_drive && bus_dout == '0, "R1", "bus_drive/dout", {32'd0, bus_dout}, 64'd0);
      check(req_ready && !done, "R1", "ready/done", {62'd0, req_ready, done}, 64'd2);

      // R4 wide ports
      cfg_n1 = 1'b1; cfg_wait = 0; cfg_d1 = 32'h1122_3344;
      xfer(30'h0000_1234, 1'b0, 4'b0000, '0, "R4");
      cfg_wait = 2;
      xfer(30'h0000_1235, 1'b1, 4'b0000, 32'hCAFE_F00D, "R4");
      cfg_wait = 0; cfg_d1 = 32'h8899_AABB;
      xfer(30'h0000_0040, 1'b0, 4'b0011, '0, "R4");

      // R3 lower lanes only with a narrow port
      cfg_n1 = 1'b0; cfg_d1 = 32'hFFEE_6655;
      xfer(30'h0000_0100, 1'b0, 4'b1100, '0, "R3");
      xfer(30'h0000_0101, 1'b1, 4'b1110, 32'h0102_0304, "R3");

      // R5 upper-only reads on a narrow port
      cfg_d1 = 32'h7777_A1B2; cfg_wait = 1;
      xfer(30'h0000_0200, 1'b0, 4'b0011, '0, "R5");
      cfg_d1 = 32'h0000_C3D4;
      xfer(30'h0000_0201, 1'b0, 4'b0111, '0, "R5");

      // R6 upper-only writes, both port widths
      cfg_n1 = 1'b1; cfg_wait = 0;
      xfer(30'h0000_0300, 1'b1, 4'b0011, 32'hA5A5_1111, "R6");
      cfg_n1 = 1'b0;
      xfer(30'h0000_0301, 1'b1, 4'b1011, 32'h5C00_2222, "R6");

      // R7 R8 split reads
      cfg_n1 = 1'b0; cfg_n2 = 1'b0; cfg_wait = 2;
      cfg_d1 = 32'h9999_3412; cfg_d2 = 32'h8888_7856;
      xfer(30'h0000_0400, 1'b0, 4'b0000, '0, "R8");
      cfg_wait = 0; cfg_d1 = 32'h0000_BB00; cfg_d2 = 32'h1111_00CC;
      xfer(30'h0000_0401, 1'b0, 4'b1001, '0, "R7");

      // R9 split write
      cfg_wait = 1;
      xfer(30'h0000_0500, 1'b1, 4'b0000, 32'hDDCC_BBAA, "R9");

      // R10 narrow indication dropped on the second half
      cfg_n2 = 1'b1; cfg_wait = 0; cfg_d1 = 32'h0000_2211; cfg_d2 = 32'h0000_4433;
      xfer(30'h0000_0600, 1'b0, 4'b0000, '0, "R10");
      cfg_n2 = 1'b0;

      // R11 R12: next request accepted in the clock carrying done
      cfg_wait = 1; cfg_d1 = 32'h0000_6655; cfg_d2 = 32'h0000_8877;
      begin
         int dummy;
         dummy = push_exp(30'h0000_0700, 1'b0, 4'b1100, '0, "R11");
         @(negedge clk);
         while (!req_ready) @(negedge clk);
         req_addr = 30'h0000_0700; req_write = 1'b0; req_be_n = 4'b1100; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         dummy = push_exp(30'h0000_0701, 1'b0, 4'b0000, '0, "R12");
         while (!done) @(negedge clk);
         check(req_ready, "R11", "req_ready with done", {63'd0, req_ready}, 64'd1);
         req_addr = 30'h0000_0701; req_be_n = 4'b0000; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check(bus_start, "R12", "bus_start after accept", {63'd0, bus_start}, 64'd1);
         check(!done, "R11", "done single pulse", {63'd0, done}, 64'd0);
         while (!done) @(negedge clk);
         @(negedge clk);
      end

      repeat (3) @(negedge clk);
      check(cyc_q.size() == 0, "R7", "pending bus cycles", 64'(cyc_q.size()), 64'd0);
      check(res_q.size() == 0, "R11", "pending results", 64'(res_q.size()), 64'd0);
      check(!bus_cyc && bus_be_n == 4'hF, "R1", "idle after run", {60'd0, bus_be_n}, 64'hF);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule